// File: doc/BRIEF.md
# Bit Field Extract Unit

This unit takes a source operand and a control word and returns a contiguous group of source bits, moved down so that the lowest selected bit lands at result bit 0. The control word carries two packed 8-bit fields: the first bit position to take and the number of bits to take. The extraction is clipped at the active operand width. A start position past the width, or a length of zero, gives a zero result. The active width is 32 bits unless the core is in its 64-bit mode and the operation asks for the wide form.

The unit sits in an integer execution pipe. Each accepted operation (`in_valid` high) produces one registered result one clock later, with `out_valid` marking it. That result carries the zero, carry and overflow flags and a mask of which flags it defines. An operation issued in an unsupported mode, or with the vector-length bit set, raises an invalid-opcode indication instead of producing a value.

Top module: `bfx_unit`

## Requirements
- R1: The start position is `ctrl[7:0]` and the length is `ctrl[15:8]`. Bits `ctrl[63:16]` have no effect on any output.
- R2: Result bit i equals source bit (start + i) for every i below the effective length. Every result bit at or above the effective length is 0.
- R3: The operand width is 64 only when `long_mode` and `wide_op` are both 1. Otherwise it is 32, and `src[63:32]` are never extracted, so `result[63:32]` is 0.
- R4: A start position greater than or equal to the operand width gives a result of 0. This includes start values up to 255.
- R5: A length of 0 gives a result of 0.
- R6: The effective length is min(length, width - start). Any length up to 255 is accepted without wrap-around. Bits past width - 1 read as 0.
- R7: `zero_flag` is 1 exactly when the result is 0. `carry_flag` and `ovf_flag` are always 0.
- R8: `flags_known` is 6'b000111 for a normal result. Its bit order is 0 zero, 1 carry, 2 overflow, 3 sign, 4 aux, 5 parity. The sign, aux and parity flags are not defined by this unit.
- R9: If `vlen` or `legacy_mode` is 1, the result has `ill_op` = 1, `result` = 0, all flags 0 and `flags_known` = 0.
- R10: `out_valid` is high in the cycle after each `in_valid` cycle and low otherwise. Outputs hold their values while no operation is issued. After reset, `out_valid` and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| src | input | 64 | Source operand |
| ctrl | input | 64 | Control word: start in [7:0], length in [15:8] |
| long_mode | input | 1 | Core is in 64-bit mode |
| wide_op | input | 1 | Operation requests 64-bit operand size |
| vlen | input | 1 | Vector-length bit of the encoding (must be 0) |
| legacy_mode | input | 1 | Core is in a mode that does not support the operation |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 64 | Extracted field, right-justified |
| zero_flag | output | 1 | Result is zero |
| carry_flag | output | 1 | Always 0 |
| ovf_flag | output | 1 | Always 0 |
| flags_known | output | 6 | Mask of flags defined by this result |
| ill_op | output | 1 | Invalid-opcode exception |

## Verification
A wrong effective length or shift amount shows up in the result of the same operation, one cycle after issue. Clipping faults only appear for start/length pairs that cross the width, so the directed cases sit on that edge in both widths. A mis-decoded width shows as nonzero upper bits, or as missing upper bits, on the very next result. A stuck exception or flag path is visible on the first legal or illegal operation that follows it, because every result register is rewritten on every issue.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int FLAG_N = 6;

  // bit positions inside the flags_known mask
  typedef enum logic [2:0] {
    FL_ZERO  = 3'd0,
    FL_CARRY = 3'd1,
    FL_OVF   = 3'd2,
    FL_SIGN  = 3'd3,
    FL_AUX   = 3'd4,
    FL_PAR   = 3'd5
  } flag_pos_e;

  function automatic logic [FLAG_N-1:0] defined_flags();
    logic [FLAG_N-1:0] m;
    m = '0;
    m[FL_ZERO]  = 1'b1;
    m[FL_CARRY] = 1'b1;
    m[FL_OVF]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int FIELD_W  = 8,
  parameter int CNT_W    = 9
) (
  input  logic [DATA_W-1:0]  ctrl,
  input  logic               long_mode,
  input  logic               wide_op,
  input  logic               vlen,
  input  logic               legacy_mode,
  output logic [FIELD_W-1:0] start,
  output logic [FIELD_W-1:0] len,
  output logic               wide_sel,
  output logic [CNT_W-1:0]   op_width,
  output logic               illegal
);
  localparam int CTRL_USED = 2 * FIELD_W;

  logic [DATA_W-CTRL_USED-1:0] ctrl_unused_hi;

  assign start          = ctrl[FIELD_W-1:0];
  assign len            = ctrl[CTRL_USED-1:FIELD_W];
  assign ctrl_unused_hi = ctrl[DATA_W-1:CTRL_USED];

  assign wide_sel = long_mode & wide_op;
  assign op_width = wide_sel ? CNT_W'(DATA_W) : CNT_W'(NARROW_W);
  assign illegal  = vlen | legacy_mode;

endmodule

// File: rtl/bfx_window.sv
module bfx_window #(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 9
) (
  input  logic [FIELD_W-1:0] start,
  input  logic [FIELD_W-1:0] len,
  input  logic [CNT_W-1:0]   op_width,
  output logic               start_oob,
  output logic [CNT_W-1:0]   eff_len,
  output logic [DATA_W-1:0]  field_mask
);
  function automatic logic [CNT_W-1:0] room_left(input logic [CNT_W-1:0] w,
                                                 input logic [CNT_W-1:0] s);
    return (s >= w) ? '0 : (w - s);
  endfunction

  function automatic logic [CNT_W-1:0] sat_min(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CNT_W-1:0] start_ext;
  logic [CNT_W-1:0] len_ext;
  logic [CNT_W-1:0] room;

  assign start_ext = CNT_W'(start);
  assign len_ext   = CNT_W'(len);
  assign start_oob = (start_ext >= op_width);
  assign room      = room_left(op_width, start_ext);
  assign eff_len   = sat_min(len_ext, room);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign field_mask[i] = (CNT_W'(i) < eff_len);
  end

endmodule

// File: rtl/bfx_shifter.sv
module bfx_shifter #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int FIELD_W  = 8
) (
  input  logic [DATA_W-1:0]  src,
  input  logic               wide_sel,
  input  logic [FIELD_W-1:0] start,
  output logic [DATA_W-1:0]  shifted
);
  localparam int STAGES = $clog2(DATA_W);

  logic [DATA_W-1:0] trimmed;
  logic [DATA_W-1:0] stage [STAGES+1];

  if (NARROW_W < DATA_W) begin : g_trim
    assign trimmed = wide_sel ? src
                              : {{(DATA_W-NARROW_W){1'b0}}, src[NARROW_W-1:0]};
  end else begin : g_notrim
    logic wide_unused;
    assign wide_unused = wide_sel;
    assign trimmed     = src;
  end

  assign stage[0] = trimmed;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign stage[s+1] = start[s] ? (stage[s] >> (2**s)) : stage[s];
  end

  if (FIELD_W > STAGES) begin : g_far
    assign shifted = (|start[FIELD_W-1:STAGES]) ? '0 : stage[STAGES];
  end else begin : g_near
    assign shifted = stage[STAGES];
  end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int FIELD_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           src,
  input  logic [DATA_W-1:0]           ctrl,
  input  logic                        long_mode,
  input  logic                        wide_op,
  input  logic                        vlen,
  input  logic                        legacy_mode,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           result,
  output logic                        zero_flag,
  output logic                        carry_flag,
  output logic                        ovf_flag,
  output logic [bfx_pkg::FLAG_N-1:0]  flags_known,
  output logic                        ill_op
);
  import bfx_pkg::*;

  localparam int LG    = $clog2(DATA_W) + 1;
  localparam int CNT_W = (LG > FIELD_W) ? LG + 1 : FIELD_W + 1;

  logic [FIELD_W-1:0] start;
  logic [FIELD_W-1:0] len;
  logic               wide_sel;
  logic [CNT_W-1:0]   op_width;
  logic               illegal;
  logic               start_oob;
  logic [CNT_W-1:0]   eff_len;
  logic [DATA_W-1:0]  field_mask;
  logic [DATA_W-1:0]  shifted;
  logic [DATA_W-1:0]  field;
  logic               field_zero;
  logic               wide_q;

  bfx_decode #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_decode (
    .ctrl(ctrl), .long_mode(long_mode), .wide_op(wide_op), .vlen(vlen),
    .legacy_mode(legacy_mode), .start(start), .len(len), .wide_sel(wide_sel),
    .op_width(op_width), .illegal(illegal)
  );

  bfx_window #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_window (
    .start(start), .len(len), .op_width(op_width), .start_oob(start_oob),
    .eff_len(eff_len), .field_mask(field_mask)
  );

  bfx_shifter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .FIELD_W(FIELD_W)) u_shifter (
    .src(src), .wide_sel(wide_sel), .start(start), .shifted(shifted)
  );

  assign field      = shifted & field_mask;
  assign field_zero = (field == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      zero_flag   <= 1'b0;
      carry_flag  <= 1'b0;
      ovf_flag    <= 1'b0;
      flags_known <= '0;
      ill_op      <= 1'b0;
      wide_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        carry_flag <= 1'b0;
        ovf_flag   <= 1'b0;
        wide_q     <= wide_sel & ~illegal;
        if (illegal) begin
          result      <= '0;
          zero_flag   <= 1'b0;
          flags_known <= '0;
          ill_op      <= 1'b1;
        end else begin
          result      <= field;
          zero_flag   <= field_zero;
          flags_known <= defined_flags();
          ill_op      <= 1'b0;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ill_op) && $stable(flags_known)));
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ill_op) |-> ((zero_flag == (result == '0)) && !carry_flag && !ovf_flag));
  assert_known_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ill_op) |-> (flags_known == 6'b000111));
  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (result[DATA_W-1:NARROW_W] == '0));
  assert_oob_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && start_oob) |-> (eff_len == '0));
  assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !start_oob) |-> (eff_len <= (op_width - CNT_W'(start))));
  assert_mask_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(field_mask) == int'(eff_len)));
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ill_op) |-> ((result == '0) && (flags_known == '0) && !zero_flag));

endmodule

// File: tb/bfx_unit_bench.sv
`timescale 1ns/1ps
module bfx_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] ctrl = '0;
  logic        long_mode = 1'b0;
  logic        wide_op = 1'b0;
  logic        vlen = 1'b0;
  logic        legacy_mode = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        zero_flag, carry_flag, ovf_flag, ill_op;
  logic [5:0]  flags_known;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bfx_unit u_bfx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .ctrl(ctrl),
    .long_mode(long_mode), .wide_op(wide_op), .vlen(vlen), .legacy_mode(legacy_mode),
    .out_valid(out_valid), .result(result), .zero_flag(zero_flag),
    .carry_flag(carry_flag), .ovf_flag(ovf_flag), .flags_known(flags_known),
    .ill_op(ill_op)
  );

  // bit-by-bit restatement of the extract rule
  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] c,
                                        input logic lm, input logic wd);
    logic [63:0] r;
    int w, st, ln;
    r  = '0;
    w  = (lm && wd) ? 64 : 32;
    st = int'(c[7:0]);
    ln = int'(c[15:8]);
    for (int i = 0; i < 64; i++)
      if (i < ln && (st + i) < w) r[i] = s[st + i];
    return r;
  endfunction

  task automatic issue(input logic [63:0] s, input logic [63:0] c, input logic lm,
                       input logic wd, input logic vl, input logic lg);
    @(negedge clk);
    src = s; ctrl = c; long_mode = lm; wide_op = wd; vlen = vl; legacy_mode = lg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string req, input logic [63:0] er, input logic ezf,
                       input logic [5:0] ek, input logic eill);
    n_checks++;
    if (out_valid !== 1'b1 || result !== er || zero_flag !== ezf || carry_flag !== 1'b0 ||
        ovf_flag !== 1'b0 || flags_known !== ek || ill_op !== eill) begin
      n_fail++;
      $display("FAIL %s: got v=%b res=%h zf=%b cf=%b of=%b known=%b ill=%b; expected v=1 res=%h zf=%b cf=0 of=0 known=%b ill=%b",
               req, out_valid, result, zero_flag, carry_flag, ovf_flag, flags_known, ill_op,
               er, ezf, ek, eill);
    end
  endtask

  task automatic run_model(input string req, input logic [63:0] s, input logic [63:0] c,
                           input logic lm, input logic wd);
    logic [63:0] e;
    e = model(s, c, lm, wd);
    issue(s, c, lm, wd, 1'b0, 1'b0);
    check(req, e, (e == '0), 6'b000111, 1'b0);
  endtask

  task automatic run_exact(input string req, input logic [63:0] s, input logic [63:0] c,
                           input logic lm, input logic wd, input logic [63:0] e);
    issue(s, c, lm, wd, 1'b0, 1'b0);
    check(req, e, (e == '0), 6'b000111, 1'b0);
  endtask

  task automatic t_reset();
    n_checks++;
    if (out_valid !== 1'b0 || result !== '0 || zero_flag !== 1'b0 || flags_known !== '0 ||
        ill_op !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: got v=%b res=%h zf=%b known=%b ill=%b; expected all zero",
               out_valid, result, zero_flag, flags_known, ill_op);
    end
  endtask

  task automatic t_basic();  // R1 R2
    run_exact("R1 basic narrow", 64'h0000_0000_DEAD_BEEF, 64'h0804, 1'b0, 1'b0, 64'hEE);
    run_exact("R2 mid field", 64'h1234_5678_9ABC_DEF0, 64'h1008, 1'b1, 1'b1, 64'hBCDE);
    run_exact("R1 high control ignored", 64'h0000_0000_DEAD_BEEF, 64'hFFFF_FFFF_FFFF_0804,
              1'b0, 1'b0, 64'hEE);
  endtask

  task automatic t_width();  // R3
    run_exact("R3 narrow drops upper src", 64'hFFFF_FFFF_0000_0000, 64'h4000, 1'b0, 1'b1, 64'h0);
    run_exact("R3 long mode without wide", 64'hFFFF_FFFF_0000_0000, 64'h4000, 1'b1, 1'b0, 64'h0);
    run_exact("R3 wide top bit", 64'h8000_0000_0000_0000, 64'h013F, 1'b1, 1'b1, 64'h1);
    run_exact("R3 wide full copy", 64'hA5A5_0F0F_1234_8765, 64'h4000, 1'b1, 1'b1,
              64'hA5A5_0F0F_1234_8765);
  endtask

  task automatic t_start_beyond();  // R4
    run_exact("R4 start at narrow width", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0820, 1'b0, 1'b0, 64'h0);
    run_exact("R4 start at wide width", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0840, 1'b1, 1'b1, 64'h0);
    run_exact("R4 start 200", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFC8, 1'b1, 1'b1, 64'h0);
    run_exact("R4 start 255", 64'hFFFF_FFFF_FFFF_FFFF, 64'h10FF, 1'b0, 1'b0, 64'h0);
  endtask

  task automatic t_zero_len();  // R5
    run_exact("R5 zero length", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0003, 1'b1, 1'b1, 64'h0);
    run_exact("R5 zero length start 0", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000, 1'b0, 1'b0, 64'h0);
  endtask

  task automatic t_saturate();  // R6
    run_exact("R6 narrow clip", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF1C, 1'b0, 1'b0, 64'hF);
    run_exact("R6 wide len 255", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF00, 1'b1, 1'b1,
              64'hFFFF_FFFF_FFFF_FFFF);
    run_exact("R6 wide last bit", 64'hFFFF_FFFF_FFFF_FFFF, 64'h803F, 1'b1, 1'b1, 64'h1);
    run_exact("R6 narrow 32 len exact", 64'hFFFF_FFFF_8000_0001, 64'h2000, 1'b0, 1'b0,
              64'h8000_0001);
  endtask

  task automatic t_flags();  // R7 R8
    run_exact("R7 zero field sets zero flag", 64'hFFFF_FFFF_FFFF_00FF, 64'h0808, 1'b1, 1'b1, 64'h0);
    run_exact("R8 nonzero result mask", 64'h0000_0000_0000_0100, 64'h0808, 1'b1, 1'b1, 64'h1);
  endtask

  task automatic t_illegal();  // R9
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0800, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R9 vector length set", 64'h0, 1'b0, 6'b000000, 1'b1);
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0800, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 legacy mode", 64'h0, 1'b0, 6'b000000, 1'b1);
    run_exact("R9 legal after illegal", 64'h0000_0000_0000_00F0, 64'h0404, 1'b0, 1'b0, 64'hF);
  endtask

  task automatic t_hold();  // R10
    logic [63:0] kept;
    run_exact("R10 issue before idle", 64'h0000_0000_0000_0ABC, 64'h0C00, 1'b0, 1'b0, 64'hABC);
    kept = result;
    @(negedge clk);
    src = '1; ctrl = 64'h0400; long_mode = 1'b1; wide_op = 1'b1; vlen = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== kept || ill_op !== 1'b0 || flags_known !== 6'b000111) begin
      n_fail++;
      $display("FAIL R10 idle hold: got v=%b res=%h ill=%b known=%b; expected v=0 res=%h ill=0 known=000111",
               out_valid, result, ill_op, flags_known, kept);
    end
    vlen = 1'b0;
  endtask

  task automatic t_sweep();  // R1 R2 R3 R6 over mixed patterns
    logic [63:0] x, c;
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 160; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      c = {x[47:16], x[63:48], x[7:0] & 8'h7F, x[15:8]};
      run_model("R2 sweep", x, c, x[3], x[5]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_width();
    t_start_beyond();
    t_zero_len();
    t_saturate();
    t_flags();
    t_illegal();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule